// File: doc/BRIEF.md
# Loop Requeue Merge Controller

This block merges two instruction streams into the single write port of a circular instruction FIFO. The enqueue input carries freshly delivered instructions. The recirculate input carries instructions coming back from the FIFO's execute end. Each item carries a two-bit kind tag that marks it as a loop-start marker, a loop-end marker or an ordinary instruction. The block has two modes. In Updating mode it loads a new loop body while it flushes the previous one. In Circulating mode it feeds the executed instructions back into the FIFO, so the loop body runs again and again.

A loop-end marker on the enqueue input stalls there. A loop-start marker on the recirculate input stalls there too. When both stall at the same time, the block swallows them together and enters Circulating mode. An abort pulse returns it to Updating mode. The pulse is already qualified by its predicate. All three streams use valid/ready handshakes. The block adds no cycle of latency between its selected input and the output.

Top module: `rq_requeue_stage`

## Requirements
- R1: After reset is released, the block is in Updating mode. An ordinary item on the enqueue input is forwarded in the first cycle, with enq_ready equal to out_ready.
- R2: In Updating mode, an enqueue item that is not a loop-end marker drives out_valid, out_kind and out_data. Its enq_ready equals out_ready.
- R3: In Updating mode, the recirculate input is discarded whenever it does not hold a loop-start marker. rec_ready is 1 whatever out_ready is, and the recirculate item never reaches the output.
- R4: In Updating mode, a loop-end marker (kind 2'b10) on the enqueue input keeps enq_ready low and out_valid low, unless it is consumed as part of a pairing.
- R5: In Updating mode, a loop-start marker (kind 2'b01) on the recirculate input keeps rec_ready low, unless it is consumed as part of a pairing.
- R6: In Updating mode, a loop-end marker on the enqueue input and a loop-start marker on the recirculate input in the same cycle, with no abort, form a pairing. A pairing raises both readies, leaves out_valid low, and puts the block in Circulating mode from the next cycle.
- R7: In Circulating mode, enq_ready is 0. out_valid, out_kind and out_data mirror the recirculate input, and rec_ready equals out_ready.
- R8: An abort pulse in Circulating mode puts the block in Updating mode from the next cycle. Routing in the abort cycle itself still follows Circulating mode.
- R9: An abort pulse in Updating mode does not change the mode. If it coincides with a pairing, it wins: both markers stay stalled with their readies low, and the mode stays Updating.
- R10: Kind code 2'b11 and kind code 2'b00 both count as ordinary instructions on either input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue item present |
| enq_kind | input | 2 | Enqueue kind tag (00/11 ordinary, 01 loop start, 10 loop end) |
| enq_data | input | DATA_W | Enqueue instruction payload |
| enq_ready | output | 1 | Enqueue item taken this cycle |
| rec_valid | input | 1 | Recirculate item present |
| rec_kind | input | 2 | Recirculate kind tag |
| rec_data | input | DATA_W | Recirculate instruction payload |
| rec_ready | output | 1 | Recirculate item taken (forwarded or discarded) |
| abort_pulse | input | 1 | Qualified loop-exit request |
| out_valid | output | 1 | Output item present |
| out_kind | output | 2 | Output kind tag |
| out_data | output | DATA_W | Output payload to the FIFO |
| out_ready | input | 1 | FIFO accepts the output item |

## Verification
The mode register is the only state, so a wrong mode shows at the ports in the first cycle after the faulty edge. If the block wrongly believes it is Circulating, it refuses ordinary enqueue items and echoes recirculating traffic. If it wrongly believes it is Updating, it drops recirculating items by raising rec_ready while out_ready is low. The bench keeps its own mode bit and compares every ready and valid on every cycle. A pairing or abort handled in the wrong cycle therefore shows up as a miscompare within one clock. Stimulus mixes directed marker, abort and collision cases with a long random run in which both markers stall and pair under random downstream backpressure.

// File: rtl/rq_pkg.sv
package rq_pkg;

   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      RQ_PLAIN = 2'b00,
      RQ_START = 2'b01,
      RQ_END   = 2'b10,
      RQ_SPARE = 2'b11
   } rq_kind_e;

   typedef enum logic {
      RQ_UPDATING    = 1'b0,
      RQ_CIRCULATING = 1'b1
   } rq_mode_e;

endpackage

// File: rtl/rq_marker_detect.sv
// Flags a valid item whose kind equals the marker this input stalls on.
module rq_marker_detect #(
   parameter int              KIND_W = rq_pkg::KIND_W,
   parameter logic [KIND_W-1:0] MARK  = rq_pkg::RQ_END
) (
   input  logic              item_valid,
   input  logic [KIND_W-1:0] item_kind,
   output logic              is_mark
);
   generate
      if (KIND_W != rq_pkg::KIND_W) begin : g_bad_width
         $error("rq_marker_detect: KIND_W must match package width");
      end
   endgenerate

   always_comb is_mark = item_valid && (item_kind == MARK);
endmodule

// File: rtl/rq_mode_reg.sv
// Holds Updating/Circulating; abort wins over a pairing in the same cycle.
module rq_mode_reg (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_fire,
   input  logic             abort_pulse,
   output rq_pkg::rq_mode_e mode
);
   import rq_pkg::*;

   rq_mode_e mode_d;

   always_comb begin
      mode_d = mode;
      unique case (mode)
         RQ_CIRCULATING: if (abort_pulse) mode_d = RQ_UPDATING;
         default:        if (pair_fire && !abort_pulse) mode_d = RQ_CIRCULATING;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= RQ_UPDATING;
      else        mode <= mode_d;
   end
endmodule

// File: rtl/rq_steer.sv
// Combinational routing of handshakes and payload for the current mode.
module rq_steer #(
   parameter int DATA_W = 24,
   parameter int KIND_W = rq_pkg::KIND_W
) (
   input  rq_pkg::rq_mode_e  mode,
   input  logic              abort_pulse,
   input  logic              enq_valid,
   input  logic              enq_end,
   input  logic [KIND_W-1:0] enq_kind,
   input  logic [DATA_W-1:0] enq_data,
   input  logic              rec_valid,
   input  logic              rec_start,
   input  logic [KIND_W-1:0] rec_kind,
   input  logic [DATA_W-1:0] rec_data,
   input  logic              out_ready,
   output logic              pair_fire,
   output logic              enq_ready,
   output logic              rec_ready,
   output logic              out_valid,
   output logic [KIND_W-1:0] out_kind,
   output logic [DATA_W-1:0] out_data
);
   import rq_pkg::*;

   logic updating;
   logic both_stalled;

   always_comb begin
      updating     = (mode == RQ_UPDATING);
      both_stalled = enq_end && rec_start;
      pair_fire    = updating && both_stalled && !abort_pulse;
   end

   always_comb begin
      if (updating) begin
         out_valid = enq_valid && !enq_end;
         out_kind  = enq_kind;
         out_data  = enq_data;
         enq_ready = enq_end   ? pair_fire : out_ready;
         rec_ready = rec_start ? pair_fire : 1'b1;
      end else begin
         out_valid = rec_valid;
         out_kind  = rec_kind;
         out_data  = rec_data;
         enq_ready = 1'b0;
         rec_ready = out_ready;
      end
   end
endmodule

// File: rtl/rq_requeue_stage.sv
module rq_requeue_stage #(
   parameter int DATA_W = 24,
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [KIND_W-1:0] enq_kind,
   input  logic [DATA_W-1:0] enq_data,
   output logic              enq_ready,
   input  logic              rec_valid,
   input  logic [KIND_W-1:0] rec_kind,
   input  logic [DATA_W-1:0] rec_data,
   output logic              rec_ready,
   input  logic              abort_pulse,
   output logic              out_valid,
   output logic [KIND_W-1:0] out_kind,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   import rq_pkg::*;

   localparam int N_IN = 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("rq_requeue_stage: DATA_W must be at least 1");
      end
      if (KIND_W != rq_pkg::KIND_W) begin : g_bad_kind
         $error("rq_requeue_stage: KIND_W must equal the package kind width");
      end
   endgenerate

   logic [N_IN-1:0]             in_valid;
   logic [N_IN-1:0][KIND_W-1:0] in_kind;
   logic [N_IN-1:0]             in_mark;
   logic                        pair_fire;
   rq_mode_e                    mode_q;

   always_comb begin
      in_valid = {rec_valid, enq_valid};
      in_kind  = {rec_kind, enq_kind};
   end

   // index 0: enqueue side stalls on loop end; index 1: recirculate side on loop start
   generate
      for (genvar gi = 0; gi < N_IN; gi++) begin : g_mark
         localparam logic [KIND_W-1:0] MK = (gi == 0) ? RQ_END : RQ_START;
         rq_marker_detect #(.KIND_W(KIND_W), .MARK(MK)) u_det (
            .item_valid (in_valid[gi]),
            .item_kind  (in_kind[gi]),
            .is_mark    (in_mark[gi])
         );
      end
   endgenerate

   rq_mode_reg u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .pair_fire   (pair_fire),
      .abort_pulse (abort_pulse),
      .mode        (mode_q)
   );

   rq_steer #(.DATA_W(DATA_W), .KIND_W(KIND_W)) u_steer (
      .mode        (mode_q),
      .abort_pulse (abort_pulse),
      .enq_valid   (enq_valid),
      .enq_end     (in_mark[0]),
      .enq_kind    (enq_kind),
      .enq_data    (enq_data),
      .rec_valid   (rec_valid),
      .rec_start   (in_mark[1]),
      .rec_kind    (rec_kind),
      .rec_data    (rec_data),
      .out_ready   (out_ready),
      .pair_fire   (pair_fire),
      .enq_ready   (enq_ready),
      .rec_ready   (rec_ready),
      .out_valid   (out_valid),
      .out_kind    (out_kind),
      .out_data    (out_data)
   );
endmodule

// File: rtl/rq_requeue_checker.sv
module rq_requeue_checker #(
   parameter int KIND_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input rq_pkg::rq_mode_e  mode,
   input logic              enq_valid,
   input logic [KIND_W-1:0] enq_kind,
   input logic              enq_ready,
   input logic              rec_valid,
   input logic [KIND_W-1:0] rec_kind,
   input logic              rec_ready,
   input logic              out_valid,
   input logic              abort_pulse
);
   import rq_pkg::*;

   logic circ, e_end, r_start, pairing;
   always_comb begin
      circ    = (mode == RQ_CIRCULATING);
      e_end   = enq_valid && (enq_kind == RQ_END);
      r_start = rec_valid && (rec_kind == RQ_START);
      pairing = !circ && e_end && r_start;
   end

   a_r7_enq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      circ |-> !enq_ready);

   a_r7_out_follows_rec: assert property (@(posedge clk) disable iff (!rst_n)
      circ |-> (out_valid == rec_valid));

   a_r6_pair_enters_circ: assert property (@(posedge clk) disable iff (!rst_n)
      (pairing && !abort_pulse) |=> circ);

   a_r8_abort_leaves_circ: assert property (@(posedge clk) disable iff (!rst_n)
      (circ && abort_pulse) |=> !circ);

   a_r9_abort_keeps_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (!circ && abort_pulse) |=> !circ);

   a_r9_collision_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (pairing && abort_pulse) |-> (!enq_ready && !rec_ready));

   a_r3_discard_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!circ && !r_start) |-> rec_ready);

   a_r4_end_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (!circ && e_end && !(r_start && !abort_pulse)) |-> (!enq_ready && !out_valid));

   a_r5_start_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (!circ && r_start && !(e_end && !abort_pulse)) |-> !rec_ready);
endmodule

bind rq_requeue_stage rq_requeue_checker #(.KIND_W(KIND_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode_q),
   .enq_valid   (enq_valid),
   .enq_kind    (enq_kind),
   .enq_ready   (enq_ready),
   .rec_valid   (rec_valid),
   .rec_kind    (rec_kind),
   .rec_ready   (rec_ready),
   .out_valid   (out_valid),
   .abort_pulse (abort_pulse)
);

// File: tb/sim_rq_requeue_stage.sv
`timescale 1ns/1ps
module sim_rq_requeue_stage;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enq_valid = 0, rec_valid = 0, abort_pulse = 0, out_ready = 0;
   logic [1:0]    enq_kind = 0, rec_kind = 0;
   logic [DW-1:0] enq_data = 0, rec_data = 0;
   logic          enq_ready, rec_ready, out_valid;
   logic [1:0]    out_kind;
   logic [DW-1:0] out_data;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 0;
   bit  m_circ = 0;   // reference mode: 1 = circulating

   always #5 clk = ~clk;

   rq_requeue_stage #(.DATA_W(DW), .KIND_W(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_data(enq_data), .enq_ready(enq_ready),
      .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_data(rec_data), .rec_ready(rec_ready),
      .abort_pulse(abort_pulse),
      .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data), .out_ready(out_ready)
   );

   task automatic cyc(input bit ev, input logic [1:0] ek, input logic [DW-1:0] ed,
                      input bit rv, input logic [1:0] rk, input logic [DW-1:0] rd,
                      input bit ordy, input bit ab, input string force_tag);
      bit e_end, r_start, pair;
      bit x_ov, x_er, x_rr;
      logic [1:0] x_k;
      logic [DW-1:0] x_d;
      string tag;
      @(negedge clk);
      enq_valid = ev; enq_kind = ek; enq_data = ed;
      rec_valid = rv; rec_kind = rk; rec_data = rd;
      out_ready = ordy; abort_pulse = ab;
      #2;
      e_end   = ev && (ek == 2'b10);
      r_start = rv && (rk == 2'b01);
      pair    = e_end && r_start;
      if (m_circ) begin
         x_ov = rv; x_k = rk; x_d = rd; x_er = 0; x_rr = ordy;
         tag = ab ? "R8" : "R7";
      end else begin
         x_ov = ev && !e_end; x_k = ek; x_d = ed;
         x_er = e_end   ? (pair && !ab) : ordy;
         x_rr = r_start ? (pair && !ab) : 1'b1;
         if (pair)                              tag = ab ? "R9" : "R6";
         else if (e_end)                        tag = "R4";
         else if (r_start)                      tag = "R5";
         else if (ab)                           tag = "R9";
         else if ((ev && ek == 2'b11) || (rv && rk == 2'b11)) tag = "R10";
         else if (rv)                           tag = "R3";
         else                                   tag = "R2";
      end
      if (force_tag != "") tag = force_tag;
      n_vec++;
      if (out_valid !== x_ov || enq_ready !== x_er || rec_ready !== x_rr ||
          (x_ov && (out_kind !== x_k || out_data !== x_d))) begin
         n_bad++;
         $display("FAIL %s: ov/er/rr/k/d got %b%b%b %h %h exp %b%b%b %h %h", tag,
                  out_valid, enq_ready, rec_ready, out_kind, out_data,
                  x_ov, x_er, x_rr, x_k, x_d);
      end
      @(posedge clk);
      if (m_circ && ab)             m_circ = 0;
      else if (!m_circ && pair && !ab) m_circ = 1;
   endtask

   initial begin
      #(10 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      if (!done) begin
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: first cycle after reset forwards ordinary enqueue item
      cyc(1, 2'b00, 24'h000005, 0, 2'b00, 0, 1, 0, "R1");
      cyc(1, 2'b00, 24'h000006, 0, 2'b00, 0, 0, 0, "R2");   // R2 with backpressure
      cyc(1, 2'b00, 24'h000007, 1, 2'b00, 24'hBEEF, 0, 0, "R3"); // R3 discard under stall
      cyc(1, 2'b10, 24'h0000AA, 0, 2'b00, 0, 1, 0, "R4");   // R4 lone loop end
      cyc(0, 2'b00, 0, 1, 2'b01, 24'h0000BB, 1, 0, "R5");   // R5 lone loop start
      cyc(1, 2'b11, 24'h000033, 1, 2'b11, 24'h44, 0, 0, "R10"); // R10 spare kind
      cyc(1, 2'b10, 24'h0000AA, 1, 2'b01, 24'hBB, 1, 1, "R9"); // R9 collision
      cyc(1, 2'b10, 24'h0000AA, 1, 2'b01, 24'hBB, 1, 0, "R6"); // R6 pairing
      cyc(1, 2'b00, 24'h000011, 1, 2'b00, 24'h000022, 1, 0, "R7");
      cyc(1, 2'b10, 24'h000011, 1, 2'b11, 24'h000023, 0, 0, "R7");
      cyc(0, 2'b00, 0, 0, 2'b00, 0, 1, 0, "R7");
      cyc(0, 2'b00, 0, 1, 2'b00, 24'h000024, 1, 1, "R8");   // R8 abort in circulate
      cyc(1, 2'b00, 24'h000055, 1, 2'b00, 24'h66, 1, 0, "R8"); // back in updating
      cyc(1, 2'b00, 24'h000056, 0, 2'b00, 0, 1, 1, "R9");   // R9 abort ignored
      cyc(1, 2'b00, 24'h000057, 1, 2'b00, 24'h67, 0, 0, "R9");
      for (int i = 0; i < 4000; i++) begin
         cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), DW'($urandom),
             $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), DW'($urandom),
             $urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0, "");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule